// File: doc/BRIEF.md
# Line-Addressed Light Matrix Controller

This block keeps the picture for a five-by-five grid of lights, each with sixteen brightness steps, and shows it by scanning one row at a time. A processor feeds it bytes in sequence through a valid/ready write stream. Each accepted byte sets the brightness of the next light on the current line. Two plain control strobes steer the write position. A select strobe marks the moment the display becomes the chosen device and sends the position back to the top line. A feed strobe starts a fresh line.

Brightness is shown by pulse-width modulation against a free-running four-bit counter. Each row stays active for one whole counter period of sixteen cycles and then hands over to the next row. Back-pressure on the write stream is simple: the ready signal is high in every cycle except those in which select or feed is asserted. A producer keeps valid and data steady until it sees ready, and the byte is stored at the position that exists after the strobe has taken effect.

Top module: `lightgrid_ctrl`

## Requirements
- R1: After reset every light level is 0, the write position is line 0 column 0, `row_o` is 5'b00001, `col_o` is 0 and `wr_ready_o` is 1.
- R2: A write is accepted in a cycle where `wr_valid_i` and `wr_ready_o` are both high. It stores bits [3:0] of `wr_data_i` as the level of the current column on the current line and then moves one column to the right. Bits [7:4] have no effect.
- R3: Once column 4 of a line has been written, later accepted writes leave every stored level unchanged until a feed or select.
- R4: A feed sets the column to 0 and moves to the next line. After line 4 it returns to line 0.
- R5: A select sets the position to line 0 column 0. When select and feed are both high in the same cycle, select wins.
- R6: `wr_ready_o` is low in any cycle where `sel_i` or `feed_i` is high. A held write is then stored at the position that results from the strobe.
- R7: A light with level L is lit in exactly L of every 16 consecutive cycles of its row. Level 0 is never lit and level 15 is lit in 15 of them.
- R8: `row_o` is one-hot, with bit r marking line r. The rows follow the order 0,1,2,3,4,0 and each row is held for 16 cycles. `col_o` bit c shows whether column c of the active row is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Device-select strobe; returns the position to the top line |
| feed_i | input | 1 | Feed strobe; starts the next line |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready; low while a strobe is present |
| wr_data_i | input | 8 | Write byte; the low nibble is the brightness level |
| row_o | output | 5 | One-hot active row strobe |
| col_o | output | 5 | Lit pattern of the active row, bit c is column c |

## Verification
Two things can fall in the same cycle: a position strobe (feed or select) and a pending write. The bench raises feed together with valid, and later select together with feed. It checks that ready is low during the strobe and that the held byte lands at column 0 of the new line. For the select-and-feed case it checks that the byte lands on line 0 rather than the next line. Each result is judged only from the brightness counts measured on the row and column outputs over a full row period.

// File: rtl/lg_pkg.sv
package lg_pkg;
  localparam int LG_LVL_W = 4;
  typedef logic [LG_LVL_W-1:0] lg_level_t;
endpackage

// File: rtl/lg_wptr.sv
module lg_wptr #(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             feed_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic             wr_en_o,
  output logic [ROW_W-1:0] wr_row_o,
  output logic [COL_W-1:0] wr_col_o
);
  localparam logic [COL_W-1:0] COL_FULL = COL_W'(COLS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             accept;

  assign wr_ready_o = !(sel_i || feed_i);
  assign accept     = wr_valid_i && wr_ready_o;
  assign wr_en_o    = accept && (col_q != COL_FULL);
  assign wr_row_o   = row_q;
  assign wr_col_o   = col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (sel_i) begin
      row_q <= '0;
      col_q <= '0;
    end else if (feed_i) begin
      col_q <= '0;
      row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
    end else if (wr_en_o) begin
      col_q <= col_q + 1'b1;
    end
  end

  // R5: select always lands on the top-left position
  a_r5_sel_top: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i |=> (row_q == '0) && (col_q == '0));
  // R4: feed from the last line wraps to line 0
  a_r4_feed_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_i && !sel_i && row_q == ROW_LAST) |=> (row_q == '0) && (col_q == '0));
  // R3: column never runs past the saturation point
  a_r3_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_FULL);
  // R3: a write on a full line does not move the position
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && col_q == COL_FULL) |=> $stable(col_q) && $stable(row_q));
  // R2: a stored write advances the column by one
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> col_q == $past(col_q) + 1'b1);
endmodule

// File: rtl/lg_store.sv
module lg_store
  import lg_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [ROW_W-1:0]          wr_row_i,
  input  logic [COL_W-1:0]          wr_col_i,
  input  lg_level_t                 wr_lvl_i,
  input  logic [ROW_W-1:0]          rd_row_i,
  output lg_level_t [COLS-1:0]      rd_lvl_o
);
  lg_level_t mem [ROWS][COLS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem[r][c] <= '0;
    end else if (wr_en_i) begin
      mem[wr_row_i][wr_col_i] <= wr_lvl_i;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_rd
    assign rd_lvl_o[c] = mem[rd_row_i][c];
  end
endmodule

// File: rtl/lg_scan.sv
module lg_scan
  import lg_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int ROW_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lg_level_t [COLS-1:0] lvl_i,
  output logic [ROW_W-1:0]     scan_row_o,
  output logic [ROWS-1:0]      row_o,
  output logic [COLS-1:0]      col_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  lg_level_t        pwm_q;
  logic [ROW_W-1:0] scan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_q  <= '0;
      scan_q <= '0;
    end else begin
      pwm_q <= pwm_q + 1'b1;
      if (pwm_q == '1)
        scan_q <= (scan_q == ROW_LAST) ? '0 : scan_q + 1'b1;
    end
  end

  assign scan_row_o = scan_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_o[r] = (scan_q == ROW_W'(r));
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_o[c] = lvl_i[c] > pwm_q;
    // R7: a dark level never lights its column
    a_r7_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i[c] == '0) |-> !col_o[c]);
  end

  // R8: exactly one row strobe at a time
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_o) == 1);
  // R8: the row only changes at the start of a PWM period
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_q != '0) |-> $stable(row_o));
endmodule

// File: rtl/lightgrid_ctrl.sv
module lightgrid_ctrl
  import lg_pkg::*;
#(
  parameter int ROWS = 5,
  parameter int COLS = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_i,
  input  logic            feed_i,
  input  logic            wr_valid_i,
  output logic            wr_ready_o,
  input  logic [7:0]      wr_data_i,
  output logic [ROWS-1:0] row_o,
  output logic [COLS-1:0] col_o
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = $clog2(COLS + 1);

  logic             wr_en;
  logic [ROW_W-1:0] wr_row;
  logic [COL_W-1:0] wr_col;
  logic [ROW_W-1:0] scan_row;
  lg_level_t [COLS-1:0] row_lvl;

  lg_wptr #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_wptr (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .feed_i(feed_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_en_o(wr_en),
    .wr_row_o(wr_row), .wr_col_o(wr_col)
  );

  lg_store #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_row_i(wr_row),
    .wr_col_i(wr_col), .wr_lvl_i(wr_data_i[LG_LVL_W-1:0]),
    .rd_row_i(scan_row), .rd_lvl_o(row_lvl)
  );

  lg_scan #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .lvl_i(row_lvl), .scan_row_o(scan_row),
    .row_o(row_o), .col_o(col_o)
  );
endmodule

// File: tb/lightgrid_ctrl_tb.sv
module lightgrid_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_i = 1'b0;
  logic       feed_i = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       wr_ready_o;
  logic [4:0] row_o;
  logic [4:0] col_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cnt [5];

  always #10 clk = ~clk;

  lightgrid_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .feed_i(feed_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_data_i(wr_data_i),
    .row_o(row_o), .col_o(col_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_valid_i = 1'b1;
    wr_data_i  = d;
    #1;
    while (!wr_ready_o) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic strobe(input bit s, input bit f);
    @(negedge clk);
    sel_i  = s;
    feed_i = f;
    @(negedge clk);
    sel_i  = 1'b0;
    feed_i = 1'b0;
  endtask

  // measure on-counts of every column of row r over one full row period (R7, R8)
  task automatic measure(input int r);
    logic [4:0] tgt;
    int held;
    tgt = 5'b1 << r;
    held = 1;
    for (int c = 0; c < 5; c++) cnt[c] = 0;
    @(negedge clk);
    while (row_o == tgt) @(negedge clk);
    while (row_o != tgt) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      if (row_o != tgt) held = 0;
      for (int c = 0; c < 5; c++) if (col_o[c]) cnt[c]++;
      @(negedge clk);
    end
    check("R8 row held 16 cycles", held, 1);
    check("R8 next row in order", int'(row_o), int'(5'b1 << ((r + 1) % 5)));
  endtask

  task automatic expect_row(input string req, input int r, input int e0, input int e1,
                            input int e2, input int e3, input int e4);
    int e [5];
    e = '{e0, e1, e2, e3, e4};
    measure(r);
    for (int c = 0; c < 5; c++) check(req, cnt[c], e[c]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 row_o", int'(row_o), 1);
    check("R1 col_o", int'(col_o), 0);
    check("R1 ready", int'(wr_ready_o), 1);
    expect_row("R1 levels zero", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_line0();
    wr(8'h00); wr(8'h05); wr(8'h0F); wr(8'hA7); wr(8'h03);
    expect_row("R2 R7 line0 levels", 0, 0, 5, 15, 7, 3);
  endtask

  task automatic t_saturate();
    wr(8'h09); wr(8'h0C);
    expect_row("R3 extra writes ignored", 0, 0, 5, 15, 7, 3);
    strobe(1'b0, 1'b1);
    wr(8'h01);
    expect_row("R4 feed starts line1", 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 4; k++) strobe(1'b0, 1'b1);
    wr(8'h02);
    expect_row("R4 wrap to line0", 0, 2, 5, 15, 7, 3);
  endtask

  task automatic t_select();
    strobe(1'b0, 1'b1);
    wr(8'h04);
    strobe(1'b1, 1'b0);
    wr(8'h06);
    expect_row("R5 select returns to top", 0, 6, 5, 15, 7, 3);
    expect_row("R5 line1 kept", 1, 4, 0, 0, 0, 0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    feed_i = 1'b1;
    wr_valid_i = 1'b1;
    wr_data_i = 8'h09;
    #1;
    check("R6 ready low during feed", int'(wr_ready_o), 0);
    @(negedge clk);
    feed_i = 1'b0;
    #1;
    check("R6 ready back high", int'(wr_ready_o), 1);
    @(negedge clk);
    wr_valid_i = 1'b0;
    expect_row("R6 held write at new line", 1, 9, 0, 0, 0, 0);
    @(negedge clk);
    sel_i = 1'b1;
    feed_i = 1'b1;
    wr_valid_i = 1'b1;
    wr_data_i = 8'h0B;
    #1;
    check("R6 ready low during select", int'(wr_ready_o), 0);
    @(negedge clk);
    sel_i = 1'b0;
    feed_i = 1'b0;
    @(negedge clk);
    wr_valid_i = 1'b0;
    expect_row("R5 select beats feed", 0, 11, 5, 15, 7, 3);
    expect_row("R5 line1 untouched", 1, 9, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_line0();
    t_saturate();
    t_wrap();
    t_select();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule